// File: doc/BRIEF.md
# Buffered PWM Timer Channel

This block is one channel of a 16-bit timer, used as a pulse-width modulator. A free-running up-counter is compared against two registers: the duty register and the period register. When the counter equals the duty register, the waveform output rises on the next clock. When the counter equals the period register, the output falls on the next clock and the counter restarts from zero. The waveform period is therefore the period value plus one clock, and the output is high for the counts strictly above the duty value up to the period value.

The duty register can be double-buffered. Software writes the next duty value into a staging register. When buffering is enabled, the hardware copies the staging value into the duty register on the same edge that a duty match raises the output. The reload is tied to the rising edge of the output, not to the counter rollover. This means a new duty value cannot tear a pulse that is already in progress.

A plain write port programs the duty, period and staging registers and the control bits. The counter value is brought out so that the phase of the waveform can be seen.

Top module: `btpwm_channel`

## Requirements
- R1: After a synchronous active-low reset, the counter is 0, the output is 0, and counting and buffering are both off. The duty, period and staging registers all hold 0xFFFF.
- R2: While the run bit is set, the counter rises by one per clock. While the run bit is clear, the counter holds its value and no match has any effect, so the output holds too.
- R3: When the running counter equals the period register, the counter is 0 on the next clock. The waveform repeats every period+1 clocks.
- R4: When the running counter equals the duty register and not the period register, the output is 1 on the next clock.
- R5: When the running counter equals the period register, the output is 0 on the next clock. This holds even when the duty register holds the same value, so the period match takes precedence.
- R6: With buffering enabled, a duty match copies the staging register into the duty register on the same edge that the output rises. A write to the staging register changes neither the output nor the duty register by itself.
- R7: With buffering disabled, the duty register changes only through a software write to it.
- R8: A write with address 0 loads the duty register, address 1 the period register, and address 2 the staging register. Address 3 is control: data bit 0 is the run bit and data bit 1 is the buffer enable.
- R9: A duty value above the period value never matches. The output then stays 0 and no buffer transfer takes place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 duty, 1 period, 2 staging, 3 control |
| wr_data | input | 16 | Write data |
| count | output | 16 | Present counter value |
| pwm_out | output | 1 | Waveform output |

## Verification
A wrong duty value appears at the output within one waveform period: the rising edge lands at the wrong counter value. A lost or early buffer transfer shows up in the period after the duty match. A counter that fails to clear shows at the count port on the very next clock after the period match. A stuck run bit shows as a count that moves or holds when it should not. The bench sweeps every small duty/period pair with buffering on and off. It predicts the count and the output level at every clock from the counter value. It carries the expected duty register forward from period to period.

// File: rtl/btpwm_pkg.sv
// Package: shared register selects and control bit positions for the
// buffered PWM timer channel. Assumes a two-bit register address.
package btpwm_pkg;
    localparam int ADDR_W       = 2;
    localparam int CTRL_RUN_BIT = 0;
    localparam int CTRL_BUF_BIT = 1;
    localparam int NUM_CMP      = 2;
    localparam int CMP_DUTY     = 0;
    localparam int CMP_PERIOD   = 1;

    typedef enum logic [ADDR_W-1:0] {
        SEL_DUTY   = 2'd0,
        SEL_PERIOD = 2'd1,
        SEL_STAGE  = 2'd2,
        SEL_CTRL   = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/btpwm_regs.sv
// Register file: holds duty, period and staging registers plus the run
// and buffer-enable bits. A software write to the duty register wins over
// a buffer transfer in the same cycle. Assumes duty_hit is already gated
// by the run bit.
module btpwm_regs
    import btpwm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [W-1:0]        wr_data,
    input  logic                duty_hit,
    output logic [W-1:0]        duty_q,
    output logic [W-1:0]        period_q,
    output logic [W-1:0]        stage_q,
    output logic                run_q,
    output logic                buf_q
);
    reg_sel_e sel;
    logic     wr_duty, wr_period, wr_stage, wr_ctrl;

    // Decode the write address into one strobe per register.
    always_comb begin
        sel       = reg_sel_e'(wr_addr);
        wr_duty   = wr_en && (sel == SEL_DUTY);
        wr_period = wr_en && (sel == SEL_PERIOD);
        wr_stage  = wr_en && (sel == SEL_STAGE);
        wr_ctrl   = wr_en && (sel == SEL_CTRL);
    end

    // Duty register: software write, else buffered reload on a duty match.
    always_ff @(posedge clk) begin
        if (!rst_n)
            duty_q <= '1;
        else if (wr_duty)
            duty_q <= wr_data;
        else if (duty_hit && buf_q)
            duty_q <= stage_q;
    end

    // Period and staging registers: software writes only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= '1;
            stage_q  <= '1;
        end else begin
            if (wr_period) period_q <= wr_data;
            if (wr_stage)  stage_q  <= wr_data;
        end
    end

    // Control bits: run gate and buffer enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            buf_q <= 1'b0;
        end else if (wr_ctrl) begin
            run_q <= wr_data[CTRL_RUN_BIT];
            buf_q <= wr_data[CTRL_BUF_BIT];
        end
    end
endmodule

// File: rtl/btpwm_counter.sv
// Up-counter: advances by one per clock while running and returns to zero
// on the clock after a period match. It wraps naturally at full scale.
// Assumes clear is only asserted while running.
module btpwm_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         clear,
    output logic [W-1:0] cnt_q
);
    // Count, clear or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (run)
            cnt_q <= clear ? '0 : cnt_q + W'(1);
    end
endmodule

// File: rtl/btpwm_compare.sv
// Comparator bank: one equality comparator per compare register, each
// qualified by the run bit. Purely combinational.
module btpwm_compare #(
    parameter int W = 16,
    parameter int N = 2
) (
    input  logic                run,
    input  logic [W-1:0]        cnt,
    input  logic [N-1:0][W-1:0] cmp,
    output logic [N-1:0]        hit
);
    // One comparator per compare register.
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit[i] = run && (cnt == cmp[i]);
    end
endmodule

// File: rtl/btpwm_wave.sv
// Output stage: the period match drives the pin low, otherwise the duty
// match drives it high, otherwise the pin holds. Period takes precedence.
module btpwm_wave (
    input  logic clk,
    input  logic rst_n,
    input  logic set_hit,
    input  logic clr_hit,
    output logic wave_q
);
    // Registered waveform level.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wave_q <= 1'b0;
        else if (clr_hit)
            wave_q <= 1'b0;
        else if (set_hit)
            wave_q <= 1'b1;
    end
endmodule

// File: rtl/btpwm_channel.sv
// Top level of one buffered PWM timer channel. It wires the register file,
// comparators, counter and output stage. Matches take effect on the next
// clock edge. Assumes a single clock and a synchronous active-low reset.
module btpwm_channel
    import btpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count,
    output logic             pwm_out
);
    logic [CNT_W-1:0]                duty_q, period_q, stage_q;
    logic                            run, buf_en;
    logic [NUM_CMP-1:0][CNT_W-1:0]   cmp_vals;
    logic [NUM_CMP-1:0]              hits;

    // Gather compare registers in comparator order.
    always_comb begin
        cmp_vals[CMP_DUTY]   = duty_q;
        cmp_vals[CMP_PERIOD] = period_q;
    end

    btpwm_regs #(.W(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .duty_hit (hits[CMP_DUTY]),
        .duty_q   (duty_q),
        .period_q (period_q),
        .stage_q  (stage_q),
        .run_q    (run),
        .buf_q    (buf_en)
    );

    btpwm_compare #(.W(CNT_W), .N(NUM_CMP)) u_cmp (
        .run (run),
        .cnt (count),
        .cmp (cmp_vals),
        .hit (hits)
    );

    btpwm_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .clear (hits[CMP_PERIOD]),
        .cnt_q (count)
    );

    btpwm_wave u_wave (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_hit (hits[CMP_DUTY]),
        .clr_hit (hits[CMP_PERIOD]),
        .wave_q  (pwm_out)
    );
endmodule

// Checker: timing properties of the channel, observed from ports and
// register state.
module btpwm_channel_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic [1:0]   wr_addr,
    input logic [W-1:0] count,
    input logic         pwm_out,
    input logic         run,
    input logic         buf_en,
    input logic [W-1:0] duty,
    input logic [W-1:0] period,
    input logic [W-1:0] stage
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (count == '0 && !pwm_out && duty == '1 && period == '1 && stage == '1 && !run && !buf_en));

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> ($stable(count) && $stable(pwm_out)));

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && count != period) |=> (count == W'($past(count) + W'(1))));

    // R3
    period_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && count == period) |=> (count == '0));

    // R4
    duty_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && count == duty && count != period) |=> pwm_out);

    // R5
    period_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && count == period) |=> !pwm_out);

    // R6
    buf_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && buf_en && count == duty && !(wr_en && wr_addr == 2'd0)) |=> (duty == $past(stage)));

    // R7
    duty_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!buf_en && !(wr_en && wr_addr == 2'd0)) |=> $stable(duty));
endmodule

bind btpwm_channel btpwm_channel_chk #(.W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .count   (count),
    .pwm_out (pwm_out),
    .run     (run),
    .buf_en  (buf_en),
    .duty    (duty_q),
    .period  (period_q),
    .stage   (stage_q)
);

// File: tb/tb_btpwm_channel.sv
module tb_btpwm_channel;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] count;
    logic         pwm_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench model state: expected duty, staging, period, buffer bit, count.
    int ea, ec, eb, ebuf, ek;

    btpwm_channel #(.CNT_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .count(count), .pwm_out(pwm_out)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic wr(input int addr, input int data);
        wr_en = 1'b1; wr_addr = 2'(addr); wr_data = W'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Check n clocks against the arithmetic model; optionally write the
    // staging register at iteration wc_at.
    task automatic run_model(input int n, input int wc_at, input int wc_val);
        for (int i = 0; i < n; i++) begin
            int k;
            k = int'(count);
            chk("R3 count", k, ek);
            chk("R4/R5 out", int'(pwm_out), (k > ea && k <= eb) ? 1 : 0);
            if (k == eb) begin
                // R6 R9: transfer only if the duty value was reachable
                if (ebuf != 0 && ea <= eb) ea = ec;
            end
            ek = (ek == eb) ? 0 : ek + 1;
            wr_en = 1'b0;
            if (i == wc_at) begin
                wr_en = 1'b1; wr_addr = 2'd2; wr_data = W'(wc_val);
                ec = wc_val;
            end
            @(negedge clk);
        end
        wr_en = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        @(negedge clk);
        // R1: reset state at the ports
        chk("R1 count", int'(count), 0);
        chk("R1 out", int'(pwm_out), 0);
        // R1 R8: start with default registers; 0xFFFF duty and period give no match
        wr(3, 1);
        for (int i = 0; i < 30; i++) begin
            chk("R1 default count", int'(count), i);
            chk("R1 default out", int'(pwm_out), 0);
            @(negedge clk);
        end

        // R2: stop and restart
        do_reset();
        wr(0, 3); wr(1, 9); wr(3, 1);
        while (count != 6) @(negedge clk);
        wr(3, 0);
        for (int i = 0; i < 10; i++) begin
            chk("R2 hold count", int'(count), 7);
            chk("R2 hold out", int'(pwm_out), 1);
            @(negedge clk);
        end
        wr(3, 1);
        chk("R2 restart count", int'(count), 7);
        @(negedge clk);
        chk("R2 resume count", int'(count), 8);

        // R3 R4 R5 R6 R7 R8 R9: sweep of small duty/period pairs
        for (int bf = 0; bf < 2; bf++) begin
            for (int b = 0; b < 7; b++) begin
                for (int a = 0; a < 8; a++) begin
                    do_reset();
                    ea = a; eb = b; ebuf = bf; ec = (a + 3) % 8; ek = 0;
                    wr(0, a); wr(1, b); wr(2, ec);
                    wr(3, 1 + 2 * bf);
                    run_model(3 * (b + 1) + 2, -1, 0);
                end
            end
        end

        // R6: staging write mid-period is picked up only at the next duty match
        do_reset();
        ea = 2; eb = 9; ebuf = 1; ec = 4; ek = 0;
        wr(0, 2); wr(1, 9); wr(2, 4); wr(3, 3);
        run_model(40, 10, 7);

        // R9: duty above period with buffering on
        do_reset();
        ea = 12; eb = 9; ebuf = 1; ec = 3; ek = 0;
        wr(0, 12); wr(1, 9); wr(2, 3); wr(3, 3);
        run_model(35, -1, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule